// File: doc/BRIEF.md
# Pipeline Debug Halt Controller

This block sits between a hardware task scheduler and a set of processing engines that run as one concurrent pipeline. It adds a debug halt: while a halt is in force, the scheduler's thread-start requests to debug-enabled engines are not granted. An engine that already holds a grant finishes its current work unit (a line for the line-based engines, a block for the block-based one) and signals a boundary, so no engine is ever stopped partway through a unit. Engines with debug disabled, such as one running in streaming mode, keep receiving grants throughout a halt.

A halt is requested either by a one-cycle user command or by an external asynchronous trigger. Execution restarts on a one-cycle user resume command or on an external asynchronous sync trigger. When every debug-enabled engine has reached its boundary with no grant outstanding, the block raises an asynchronous "halted" trigger toward the debug fabric. All three asynchronous triggers use a four-phase request/acknowledge handshake with two-flop synchronizers on the incoming signal. A per-engine status vector shows which engines are currently parked, and a constant capability vector shows which debug features are built in.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset no halt is in force, `eng_halted`, `trig_halt_ack`, `trig_sync_ack` and `halted_trig_req` are 0, and `dbg_cap` reads 4'b1111 (bit 0 external halt input, bit 1 external sync input, bit 2 halted trigger output, bit 3 user halt/resume commands).
- R2: While a halt is in force, a debug-enabled engine (`dbg_en[i]`=1) receives no new grant; otherwise `eng_start_gnt[i]` follows `eng_start_req[i]` in the same cycle when the engine has no grant outstanding.
- R3: A `cfg_resume` pulse or an accepted external sync trigger clears a halt at the next clock edge, after which held requests are granted.
- R4: `eng_halted[i]` is 1 exactly when a halt is in force, `dbg_en[i]` is 1 and engine i has no grant outstanding; an engine granted before the halt keeps running until its `eng_boundary` pulse.
- R5: An engine holds at most one grant: after a grant, no further grant is given to it until an `eng_boundary[i]` pulse.
- R6: An engine with `dbg_en[i]`=0 keeps receiving grants while a halt is in force.
- R7: `trig_halt_req` and `trig_sync_req` pass two synchronizer flops; the matching acknowledge rises on the third clock edge after the request rises and falls on the third edge after it falls, and each request phase yields exactly one internal event.
- R8: `halted_trig_req` rises one edge after all debug-enabled engines are halted, is raised once per halt, stays high until the synchronized `halted_trig_ack` is seen (then falls one edge later), and is not raised while that acknowledge is high.
- R9: A resume that arrives while no halt is in force has no effect.
- R10: A halt request arriving in the same cycle as a resume of an active halt is applied one edge after the resume takes effect.
- R11: A `cfg_halt` pulse puts the halt in force at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_halt | input | 1 | One-cycle user halt command |
| cfg_resume | input | 1 | One-cycle user resume command |
| dbg_en | input | N_ENG | Per-engine debug enable |
| trig_halt_req | input | 1 | External halt trigger request (asynchronous) |
| trig_halt_ack | output | 1 | External halt trigger acknowledge |
| trig_sync_req | input | 1 | External sync (resume) trigger request (asynchronous) |
| trig_sync_ack | output | 1 | External sync trigger acknowledge |
| halted_trig_req | output | 1 | Halted trigger request toward the debug fabric |
| halted_trig_ack | input | 1 | Halted trigger acknowledge (asynchronous) |
| eng_start_req | input | N_ENG | Scheduler thread-start request per engine |
| eng_start_gnt | output | N_ENG | Thread-start grant per engine |
| eng_boundary | input | N_ENG | Engine reached its line or block boundary |
| eng_halted | output | N_ENG | Per-engine halted status |
| dbg_cap | output | 4 | Debug capability vector |

## Verification
A stuck or lost halt flag shows within one cycle as a grant given to, or withheld from, a debug-enabled engine with a pending request, and as a wrong `eng_halted` vector. A lost outstanding-grant flag shows as a second grant before the boundary pulse, or as an engine reported parked while it still runs. Handshake state errors appear at the acknowledge and halted-trigger ports a fixed number of edges after a request edge, so the bench samples those ports on exact edge counts instead of waiting for an eventual change.

// File: rtl/dhc_pkg.sv
package dhc_pkg;
    localparam int CAP_W          = 4;
    localparam int CAP_EXT_HALT   = 0;
    localparam int CAP_EXT_SYNC   = 1;
    localparam int CAP_HALTED_OUT = 2;
    localparam int CAP_USER_CTRL  = 3;

    typedef struct packed {
        logic ack;
    } rx_state_t;

    typedef struct packed {
        logic req;
        logic issued;
    } tx_state_t;
endpackage

// File: rtl/dhc_sync.sv
module dhc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[LAST-1:0], d};
        q       = chain_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end
endmodule

// File: rtl/dhc_trig_rx.sv
module dhc_trig_rx
    import dhc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic ack,
    output logic evt
);
    logic      req_s;
    rx_state_t st_d, st_q;

    dhc_sync #(.STAGES(STAGES)) u_req_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (req_async),
        .q    (req_s)
    );

    always_comb begin
        st_d.ack = req_s;
        evt      = req_s & ~st_q.ack;
        ack      = st_q.ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // one event per request phase
    p_single_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
    p_ack_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req_s) |=> !ack);
endmodule

// File: rtl/dhc_trig_tx.sv
module dhc_trig_tx
    import dhc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic rearm,
    input  logic ack_async,
    output logic req
);
    logic      ack_s;
    logic      launch;
    tx_state_t st_d, st_q;

    dhc_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ack_async),
        .q    (ack_s)
    );

    always_comb begin
        launch    = fire & ~st_q.issued & ~st_q.req & ~ack_s;
        st_d.req  = st_q.req ? ~ack_s : launch;
        st_d.issued = rearm ? 1'b0 : (st_q.issued | launch);
        req       = st_q.req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack_s) |=> req);
    p_no_raise_on_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && ack_s) |=> !req);
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dhc_pkg::*;
#(
    parameter int N_ENG       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_halt,
    input  logic             cfg_resume,
    input  logic [N_ENG-1:0] dbg_en,
    input  logic             trig_halt_req,
    output logic             trig_halt_ack,
    input  logic             trig_sync_req,
    output logic             trig_sync_ack,
    output logic             halted_trig_req,
    input  logic             halted_trig_ack,
    input  logic [N_ENG-1:0] eng_start_req,
    output logic [N_ENG-1:0] eng_start_gnt,
    input  logic [N_ENG-1:0] eng_boundary,
    output logic [N_ENG-1:0] eng_halted,
    output logic [CAP_W-1:0] dbg_cap
);
    typedef struct packed {
        logic             halt;
        logic             pend;
        logic [N_ENG-1:0] busy;
    } ctl_t;

    ctl_t             d, q;
    logic             ext_halt_evt, ext_sync_evt;
    logic             halt_evt, resume_evt, all_halted;
    logic [N_ENG-1:0] gate;

    dhc_trig_rx #(.STAGES(SYNC_STAGES)) u_halt_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_async(trig_halt_req),
        .ack      (trig_halt_ack),
        .evt      (ext_halt_evt)
    );

    dhc_trig_rx #(.STAGES(SYNC_STAGES)) u_sync_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_async(trig_sync_req),
        .ack      (trig_sync_ack),
        .evt      (ext_sync_evt)
    );

    dhc_trig_tx #(.STAGES(SYNC_STAGES)) u_halted_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (all_halted),
        .rearm    (~q.halt),
        .ack_async(halted_trig_ack),
        .req      (halted_trig_req)
    );

    always_comb begin
        halt_evt   = cfg_halt | ext_halt_evt;
        resume_evt = cfg_resume | ext_sync_evt;
        gate       = {N_ENG{q.halt}} & dbg_en;

        eng_start_gnt = eng_start_req & ~q.busy & ~gate;
        eng_halted    = gate & ~q.busy;
        all_halted    = q.halt & ((q.busy & dbg_en) == '0);

        d      = q;
        d.busy = (q.busy & ~eng_boundary) | eng_start_gnt;
        if (q.halt && resume_evt) begin
            d.halt = 1'b0;
            d.pend = halt_evt;
        end else begin
            d.halt = q.halt | halt_evt | q.pend;
            d.pend = 1'b0;
        end

        dbg_cap                 = '0;
        dbg_cap[CAP_EXT_HALT]   = 1'b1;
        dbg_cap[CAP_EXT_SYNC]   = 1'b1;
        dbg_cap[CAP_HALTED_OUT] = 1'b1;
        dbg_cap[CAP_USER_CTRL]  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_resume_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.halt && resume_evt) |=> !q.halt);
    p_idle_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.halt && !q.pend && !halt_evt && resume_evt) |=> !q.halt);
    p_deferred_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.halt && resume_evt && halt_evt) |=> ##1 q.halt);

    for (genvar i = 0; i < N_ENG; i++) begin : g_eng_chk
        p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (q.busy[i] && !eng_boundary[i]) |=> !eng_start_gnt[i]);
    end
endmodule

// File: tb/dbg_halt_ctrl_bench.sv
module dbg_halt_ctrl_bench;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_halt = 1'b0, cfg_resume = 1'b0;
    logic [N-1:0] dbg_en = '0;
    logic         trig_halt_req = 1'b0, trig_sync_req = 1'b0, halted_trig_ack = 1'b0;
    logic         trig_halt_ack, trig_sync_ack, halted_trig_req;
    logic [N-1:0] eng_start_req = '0, eng_boundary = '0;
    logic [N-1:0] eng_start_gnt, eng_halted;
    logic [3:0]   dbg_cap;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    dbg_halt_ctrl #(.N_ENG(N), .SYNC_STAGES(2)) u_dbg_halt_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_halt(cfg_halt), .cfg_resume(cfg_resume),
        .dbg_en(dbg_en), .trig_halt_req(trig_halt_req), .trig_halt_ack(trig_halt_ack),
        .trig_sync_req(trig_sync_req), .trig_sync_ack(trig_sync_ack),
        .halted_trig_req(halted_trig_req), .halted_trig_ack(halted_trig_ack),
        .eng_start_req(eng_start_req), .eng_start_gnt(eng_start_gnt),
        .eng_boundary(eng_boundary), .eng_halted(eng_halted), .dbg_cap(dbg_cap)
    );

    // {req[2:0], bnd[2:0], halt, resume, exp_gnt[2:0], exp_halted[2:0]}, dbg_en = 3'b011
    localparam logic [13:0] VEC [17] = '{
        14'b111_000_0_0_111_000, 14'b111_000_0_0_000_000, 14'b000_001_1_0_000_000,
        14'b111_000_0_0_000_001, 14'b111_110_0_0_000_001, 14'b111_000_0_0_100_011,
        14'b000_100_0_0_000_011, 14'b111_000_0_1_100_011, 14'b011_000_0_0_011_000,
        14'b000_000_0_1_000_000, 14'b000_111_0_0_000_000, 14'b000_000_1_0_000_000,
        14'b001_000_1_1_000_011, 14'b001_000_0_0_001_000, 14'b010_000_0_0_000_010,
        14'b000_001_0_1_000_010, 14'b000_000_0_0_000_000
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_halt = 0; cfg_resume = 0; trig_halt_req = 0;
        trig_sync_req = 0; halted_trig_ack = 0; eng_start_req = '0; eng_boundary = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        dbg_en = 3'b011;
        do_reset();
        // R1 reset state
        check("R1 halted status", 8'(eng_halted), 8'h0);
        check("R1 halt ack", 8'(trig_halt_ack), 8'h0);
        check("R1 sync ack", 8'(trig_sync_ack), 8'h0);
        check("R1 halted trigger", 8'(halted_trig_req), 8'h0);
        check("R1 capability", 8'(dbg_cap), 8'hF);

        // table walk: R2 R3 R4 R5 R6 R9 R10 R11
        for (int i = 0; i < 17; i++) begin
            {eng_start_req, eng_boundary, cfg_halt, cfg_resume} = VEC[i][13:6];
            #1;
            check($sformatf("R2 R5 R6 R3 grant row %0d", i), 8'(eng_start_gnt), 8'(VEC[i][5:3]));
            check($sformatf("R4 R9 R10 R11 status row %0d", i), 8'(eng_halted), 8'(VEC[i][2:0]));
            step();
        end
        {eng_start_req, eng_boundary, cfg_halt, cfg_resume} = '0;

        // external halt trigger and halted trigger handshake
        do_reset();
        trig_halt_req = 1'b1;
        step(); step();
        check("R7 halt ack after two edges", 8'(trig_halt_ack), 8'h0);
        step();
        check("R7 halt ack on third edge", 8'(trig_halt_ack), 8'h1);
        check("R4 parked after ext halt", 8'(eng_halted), 8'h3);
        check("R8 halted trigger not yet", 8'(halted_trig_req), 8'h0);
        step();
        check("R8 halted trigger raised", 8'(halted_trig_req), 8'h1);
        trig_halt_req = 1'b0;
        step(); step();
        check("R7 halt ack held", 8'(trig_halt_ack), 8'h1);
        step();
        check("R7 halt ack dropped", 8'(trig_halt_ack), 8'h0);
        halted_trig_ack = 1'b1;
        step(); step();
        check("R8 halted request held until ack seen", 8'(halted_trig_req), 8'h1);
        step();
        check("R8 halted request dropped", 8'(halted_trig_req), 8'h0);
        halted_trig_ack = 1'b0;
        repeat (4) step();
        check("R8 halted request once per halt", 8'(halted_trig_req), 8'h0);

        // external sync resume
        eng_start_req = 3'b001;
        #1;
        check("R2 grant held during ext halt", 8'(eng_start_gnt), 8'h0);
        trig_sync_req = 1'b1;
        step(); step();
        check("R7 sync ack after two edges", 8'(trig_sync_ack), 8'h0);
        step();
        check("R7 sync ack on third edge", 8'(trig_sync_ack), 8'h1);
        check("R3 grant after ext sync", 8'(eng_start_gnt), 8'h1);
        check("R3 status cleared", 8'(eng_halted), 8'h0);
        eng_start_req = '0;
        trig_sync_req = 1'b0;
        repeat (3) step();
        check("R7 sync ack dropped", 8'(trig_sync_ack), 8'h0);

        // user halt and resume pulses
        cfg_halt = 1'b1;
        step();
        cfg_halt = 1'b0;
        check("R11 user halt next edge", 8'(eng_halted), 8'h3);
        cfg_resume = 1'b1;
        step();
        cfg_resume = 1'b0;
        check("R3 user resume next edge", 8'(eng_halted), 8'h0);
        eng_start_req = 3'b011;
        #1;
        check("R3 grants after user resume", 8'(eng_start_gnt), 8'h3);
        eng_start_req = '0;
        step();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule